// File: doc/BRIEF.md
# I2C Serial EEPROM Responder

This block is an I2C target that acts like a small serial EEPROM with a 16-bit byte address. A fast system clock oversamples the open-drain SCL and SDA lines. The block detects start, repeated-start and stop conditions and decodes the control byte. It then takes a two-byte memory address and either stores one data byte or returns one data byte. Storage is an internal register array indexed by the low `MEM_AW` bits of the 16-bit address.

A write is committed only when the master's stop arrives. The block then enters a busy window of `BUSY_CYCLES` system clocks. During that window it leaves its own control byte unacknowledged, so the master has to poll. A random read is a dummy write of the address, then a repeated start, then the read control byte. The block answers with one data byte, MSB first.

The block never drives SDA high. Its single SDA output is an enable that pulls the line to 0, and the board's pull-up supplies every 1.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The block accepts a control byte only when its upper seven bits equal `DEV_ADDR` (default 1010000). Bit 0 selects the direction: 0 means write, 1 means read. For any other control byte it leaves SDA released on the ninth clock and ignores the bus until the next start or stop.
- R2: For every accepted byte (control, address high, address low, write data), the block pulls SDA low for the whole ninth SCL clock. It releases SDA after that clock's falling edge.
- R3: The sequence start, 0xA0, address high, address low, data, stop stores the data at the low `MEM_AW` bits of the 16-bit address. Address 0x1234 and address 0x0034 therefore name the same byte.
- R4: After start, 0xA0, address high, address low, repeated start and 0xA1, the block returns the byte at that address, MSB first. SDA changes only while SCL is low, and the block releases SDA for the master's ninth (acknowledge) clock.
- R5: After the stop that commits a write, the block does not acknowledge its control byte for `BUSY_CYCLES` system clocks. After that window it acknowledges again.
- R6: A stop that arrives before the data byte stores nothing and starts no busy window.
- R7: A start at any point, including inside a byte, aborts the transfer in progress and restarts decoding at the control byte. A pending write that is followed by a repeated start instead of a stop is discarded.
- R8: After reset, SDA is released and every memory byte reads as 0xFF.
- R9: After the write data byte, any further byte in the same transfer is not acknowledged, and only the first data byte is stored.
- R10: The SDA pull-down enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions check four things on every cycle. The pull-down enable moves only while synchronized SCL is low. The enable holds through each acknowledge clock and drops after the last transmitted bit. A control byte arriving during the busy window, or a byte after the write data, sends the block back to idle without an acknowledge. The busy window opens only when a write commits. Other behaviour shows only across whole bus transactions, and the directed scenarios cover it. These include the stored and returned byte values and address aliasing on the low bits. They also include the length of the busy window as the master's polling sees it, and that early stops, mid-byte starts and repeated starts leave the memory untouched.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX
    } bus_state_e;

    typedef enum logic [2:0] {
        K_CTRL,
        K_ADDR_HI,
        K_ADDR_LO,
        K_DATA,
        K_DONE
    } byte_kind_e;

    typedef struct packed {
        logic        valid;
        logic [15:0] addr;
        logic [7:0]  data;
    } wr_req_t;

    localparam int BYTE_BITS = 8;

    function automatic logic ctrl_match(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int TOP = STAGES;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
        end
    end

    logic scl_prev, sda_prev;
    assign scl_o      = scl_pipe[TOP-1];
    assign sda_o      = sda_pipe[TOP-1];
    assign scl_prev   = scl_pipe[TOP];
    assign sda_prev   = sda_pipe[TOP];
    assign scl_rise_o = scl_o & ~scl_prev;
    assign scl_fall_o = ~scl_o & scl_prev;
    assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
    assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;

endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
    parameter int BUSY_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    output logic busy_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (kick_i)
            remain <= LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy_o = (remain != '0);

    // R5
    busy_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(kick_i));

endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [DW-1:0] ERASED = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
        end else if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];

    // R3
    mem_store_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && raddr_i == waddr_i) |=> (rdata_o == $past(wdata_i)));

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eep_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1010000,
    parameter int         MEM_AW      = 8,
    parameter int         BUSY_CYCLES = 1000000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int BCW = $clog2(BYTE_BITS + 1);
    localparam logic [BCW-1:0] LAST_RX = BCW'(BYTE_BITS);
    localparam logic [BCW-1:0] LAST_TX = BCW'(BYTE_BITS - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    bus_state_e     state;
    byte_kind_e     kind;
    logic [7:0]     shreg;
    logic [7:0]     txreg;
    logic [BCW-1:0] bcnt;
    logic           go_tx;
    logic [15:0]    addr;
    wr_req_t        pend;
    logic           pull;
    logic           busy;
    logic           commit;
    logic [7:0]     rdata;
    logic           take_byte;
    logic           byte_end;

    assign commit   = stop_ev & pend.valid;
    assign byte_end = (state == ST_RX) && scl_fall && (bcnt == LAST_RX);

    eep_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst(rst), .kick_i(commit), .busy_o(busy)
    );

    eep_mem #(.AW(MEM_AW), .DW(8), .ERASED(8'hFF)) u_mem (
        .clk(clk), .rst(rst),
        .we_i(commit), .waddr_i(pend.addr[MEM_AW-1:0]), .wdata_i(pend.data),
        .raddr_i(addr[MEM_AW-1:0]), .rdata_o(rdata)
    );

    always_comb begin
        unique case (kind)
            K_CTRL:  take_byte = ctrl_match(shreg, DEV_ADDR) && !busy;
            K_DONE:  take_byte = 1'b0;
            default: take_byte = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            kind  <= K_CTRL;
            shreg <= '0;
            txreg <= '0;
            bcnt  <= '0;
            go_tx <= 1'b0;
            addr  <= '0;
            pend  <= '0;
            pull  <= 1'b0;
        end else if (start_ev) begin
            state      <= ST_RX;
            kind       <= K_CTRL;
            bcnt       <= '0;
            go_tx      <= 1'b0;
            pend.valid <= 1'b0;
            pull       <= 1'b0;
        end else if (stop_ev) begin
            state      <= ST_IDLE;
            go_tx      <= 1'b0;
            pend.valid <= 1'b0;
            pull       <= 1'b0;
        end else begin
            unique case (state)
                ST_RX: begin
                    if (scl_rise && bcnt != LAST_RX) begin
                        shreg <= {shreg[6:0], sda_s};
                        bcnt  <= bcnt + 1'b1;
                    end else if (byte_end) begin
                        bcnt <= '0;
                        if (take_byte) begin
                            state <= ST_ACK;
                            pull  <= 1'b1;
                            unique case (kind)
                                K_CTRL: begin
                                    go_tx <= shreg[0];
                                    kind  <= shreg[0] ? K_DONE : K_ADDR_HI;
                                end
                                K_ADDR_HI: begin
                                    addr[15:8] <= shreg;
                                    kind       <= K_ADDR_LO;
                                end
                                K_ADDR_LO: begin
                                    addr[7:0] <= shreg;
                                    kind      <= K_DATA;
                                end
                                default: begin
                                    pend <= '{valid: 1'b1, addr: addr, data: shreg};
                                    kind <= K_DONE;
                                end
                            endcase
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (go_tx) begin
                            state <= ST_TX;
                            txreg <= rdata;
                            pull  <= ~rdata[7];
                            go_tx <= 1'b0;
                            bcnt  <= '0;
                        end else begin
                            state <= ST_RX;
                            pull  <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bcnt == LAST_TX) begin
                            state <= ST_IDLE;
                            pull  <= 1'b0;
                        end else begin
                            txreg <= {txreg[6:0], 1'b0};
                            pull  <= ~txreg[6];
                            bcnt  <= bcnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull_o = pull;

    logic unused_bits;
    assign unused_bits = ^{pend.addr[15:MEM_AW], txreg[7]};

    // R10
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_pull_o != $past(sda_pull_o)) |-> !scl_s);

    // R2
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK && !scl_fall && !start_ev && !stop_ev) |=> sda_pull_o);

    // R4
    tx_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX && scl_fall && bcnt == LAST_TX && !start_ev && !stop_ev)
        |=> !sda_pull_o);

    // R5
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_end && kind == K_CTRL && busy && !start_ev && !stop_ev)
        |=> (state == ST_IDLE && !sda_pull_o));

    // R9
    extra_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_end && kind == K_DONE && !start_ev && !stop_ev)
        |=> (state == ST_IDLE && !sda_pull_o));

endmodule

// File: tb/i2c_eeprom_target_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb;

    localparam int BUSY = 3000;
    localparam int H    = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic sda_line;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // open-drain bus: pull-up gives 1 unless someone pulls low
    assign sda_line = m_sda & ~sda_pull;

    i2c_eeprom_target #(
        .DEV_ADDR(7'b1010000), .MEM_AW(8), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_pull_o(sda_pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hp();
        wait_n(H);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; hp();
        m_sda = 1'b0; hp();
        m_scl = 1'b0; hp();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b0; hp();
        m_scl = 1'b0; hp();
    endtask

    task automatic bus_stop();
        wait_n(4);
        m_sda = 1'b0; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b1; hp();
    endtask

    task automatic put_bit(input logic b, output logic s);
        wait_n(4);
        m_sda = b; hp();
        m_scl = 1'b1; wait_n(H / 2);
        s = sda_line; wait_n(H / 2);
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(b[i], s);
        put_bit(1'b1, ack);
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] b, output logic rel);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            put_bit(1'b1, s);
            b = {b[6:0], s};
        end
        wait_n(4);
        m_sda = nack; hp();
        m_scl = 1'b1; wait_n(H / 2);
        rel = ~sda_pull; wait_n(H / 2);
        m_scl = 1'b0;
    endtask

    task automatic do_write(input string req, input logic [15:0] a, input logic [7:0] d);
        logic k;
        bus_start();
        send_byte(8'hA0, k);   chk(req, k, 0);
        send_byte(a[15:8], k); chk(req, k, 0);
        send_byte(a[7:0], k);  chk(req, k, 0);
        send_byte(d, k);       chk(req, k, 0);
        wait_n(8);
        chk({req, " release after ack"}, sda_pull, 0);
        bus_stop();
    endtask

    task automatic do_read(input string req, input logic [15:0] a, output logic [7:0] d);
        logic k, rel;
        bus_start();
        send_byte(8'hA0, k);   chk(req, k, 0);
        send_byte(a[15:8], k); chk(req, k, 0);
        send_byte(a[7:0], k);  chk(req, k, 0);
        bus_rstart();
        send_byte(8'hA1, k);   chk(req, k, 0);
        get_byte(1'b1, d, rel);
        chk({req, " released on master nack"}, rel, 1);
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R8 pull idle after reset", sda_pull, 0);
        do_read("R8 read erased", 16'h0005, d);
        chk("R8 erased value", d, 8'hFF);
    endtask

    task automatic t_write_poll_read();
        logic k;
        logic [7:0] d;
        do_write("R2 R3 write acks", 16'h0012, 8'h5A);
        bus_start();
        send_byte(8'hA0, k);
        chk("R5 nack while busy", k, 1);
        bus_stop();
        wait_n(BUSY);
        bus_start();
        send_byte(8'hA0, k);
        chk("R5 ack after busy window", k, 0);
        bus_stop();
        do_read("R4 random read", 16'h0012, d);
        chk("R3 R4 readback", d, 8'h5A);
    endtask

    task automatic t_wrong_addr();
        logic k;
        bus_start();
        send_byte(8'hA2, k);
        chk("R1 other address nack", k, 1);
        bus_stop();
        bus_start();
        send_byte(8'hB1, k);
        chk("R1 other address read nack", k, 1);
        bus_stop();
    endtask

    task automatic t_alias();
        logic [7:0] d;
        do_write("R3 high address write", 16'h1234, 8'hC3);
        wait_n(BUSY + 50);
        do_read("R3 alias read", 16'h0034, d);
        chk("R3 low-bit alias", d, 8'hC3);
        do_write("R3 second write", 16'h0070, 8'h81);
        wait_n(BUSY + 50);
        do_read("R4 msb-first read", 16'h0070, d);
        chk("R4 msb-first pattern", d, 8'h81);
    endtask

    task automatic t_early_stop();
        logic k;
        logic [7:0] d;
        bus_start();
        send_byte(8'hA0, k);
        send_byte(8'h00, k);
        send_byte(8'h40, k);
        bus_stop();
        bus_start();
        send_byte(8'hA0, k);
        chk("R6 no busy after early stop", k, 0);
        bus_stop();
        do_read("R6 read", 16'h0040, d);
        chk("R6 nothing stored", d, 8'hFF);
    endtask

    task automatic t_abort();
        logic k, s;
        logic [7:0] d;
        bus_start();
        send_byte(8'hA0, k);
        put_bit(1'b0, s);
        put_bit(1'b1, s);
        put_bit(1'b0, s);
        bus_rstart();
        send_byte(8'hA0, k);
        chk("R7 control after mid-byte start", k, 0);
        send_byte(8'h00, k);
        send_byte(8'h50, k);
        send_byte(8'h77, k);
        chk("R7 data acked", k, 0);
        bus_rstart();
        bus_stop();
        bus_start();
        send_byte(8'hA0, k);
        chk("R7 no busy after discarded write", k, 0);
        bus_stop();
        do_read("R7 read", 16'h0050, d);
        chk("R7 discarded write", d, 8'hFF);
    endtask

    task automatic t_extra_byte();
        logic k;
        logic [7:0] d;
        bus_start();
        send_byte(8'hA0, k);
        send_byte(8'h00, k);
        send_byte(8'h60, k);
        send_byte(8'h11, k);
        chk("R9 data acked", k, 0);
        send_byte(8'h22, k);
        chk("R9 extra byte nack", k, 1);
        bus_stop();
        wait_n(BUSY + 50);
        do_read("R9 read first", 16'h0060, d);
        chk("R9 first byte stored", d, 8'h11);
        do_read("R9 read next", 16'h0061, d);
        chk("R9 next byte untouched", d, 8'hFF);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_n(10);
        rst = 1'b0;
        wait_n(10);
        t_reset();
        t_write_poll_read();
        t_wrong_addr();
        t_alias();
        t_early_stop();
        t_abort();
        t_extra_byte();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule